// File: doc/BRIEF.md
# Register-Based Fully-Associative Instruction Cache

This block is a small, read-only instruction cache placed between a processor's instruction fetch port and a slow memory. Tags, valid bits and line data are all held in flip-flops, so no embedded RAM is used. Every fetch address is compared against all stored tags at once. A hit returns the 32-bit instruction word in the same cycle. A miss holds the requester stalled and asks a separate line-read engine for the whole line. The engine returns the missing word first and then wraps around the line.

The line that a miss replaces is an empty line if one exists. Otherwise it is the least recently used line, where both hits and fills count as use. The requester is released in the cycle the first returned word arrives, because that word is forwarded straight to it while the rest of the line is still arriving. A maintenance port covers both the processor's cache flush and its cache initialize command. In either case it drops the valid bit of the line holding a given address, or of every line. If that happens while the line is being filled, the line stays invalid once the fill ends.

Top module: `flop_icache`

## Requirements
- R1: After reset every line is invalid and `mem_req` is low, so the first fetch to any address misses.
- R2: Any memory line can occupy any cache line. Up to LINES different memory lines stay resident together, even when their addresses agree in all low-order bits.
- R3: A fetch whose line is resident and valid keeps `fetch_wait` low and returns the stored word on `fetch_data` in the same cycle. No memory request is raised for it.
- R4: A fetch that misses while no fill is running drives `fetch_wait` high. In the next cycle `mem_req` is high, with `mem_addr` equal to the fetch byte address with bits [1:0] cleared.
- R5: `mem_req` stays high and `mem_addr` stays stable until the cycle in which `mem_ack` is high.
- R6: After the acknowledge, the line arrives as LINE_BITS/32 beats marked by `mem_rvalid`. The beats start with the requested word and wrap around modulo the words per line. The first beat is passed to `fetch_data` with `fetch_wait` low in that same cycle, and every word of the line is then served correctly on later hits.
- R7: A miss replaces the lowest-numbered invalid line if one exists, otherwise the least recently used line. A hit and a fill each mark their line as most recently used.
- R8: `maint_valid` high with `maint_all` low invalidates only the line holding `maint_addr`, so its next fetch misses. The other lines keep hitting.
- R9: `maint_valid` high with `maint_all` high invalidates every line.
- R10: If a maintenance command covers the line currently being filled, that line is still invalid when the fill completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Fetch request present; the address is held while `fetch_wait` is high |
| fetch_addr | input | ADDR_W | Fetch byte address |
| fetch_data | output | 32 | Instruction word returned |
| fetch_wait | output | 1 | Requester must stall and hold its request |
| mem_req | output | 1 | Line read request to the fetch engine |
| mem_addr | output | ADDR_W | Byte address of the missing word |
| mem_ack | input | 1 | Fetch engine accepted the request |
| mem_rvalid | input | 1 | A returned word is present |
| mem_rdata | input | 32 | Returned word |
| maint_valid | input | 1 | Invalidate command strobe |
| maint_all | input | 1 | 1: invalidate all lines; 0: only the line holding `maint_addr` |
| maint_addr | input | ADDR_W | Address selecting the line to invalidate |

## Verification
The bench builds the cache with four lines of 64 bits and a 12-bit address. With these values every replacement rank, each wrap start within a line and lines that share all low-order bits are all exercised in a few hundred fetches. A long pseudo-random sweep over six memory lines, mixed with single-line invalidations, keeps the cache under constant eviction pressure. An arithmetic model in the bench predicts a hit or a miss for each fetch, and a fixed address-to-data formula gives the expected word. A directed case sends an invalidate-all while a request is still waiting for its acknowledge.

// File: rtl/flop_icache_pkg.sv
package flop_icache_pkg;

    localparam int unsigned WORD_BITS = 32;
    localparam int unsigned BYTE_OFF  = 2;
    localparam int unsigned MAX_LINES = 16;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_REQ  = 2'd1,
        FS_FILL = 2'd2
    } fill_state_e;

    typedef struct packed {
        logic valid;
        logic all;
    } maint_cmd_t;

    function automatic int unsigned words_per_line(input int unsigned line_bits);
        return line_bits / WORD_BITS;
    endfunction

    // lowest set bit of a (zero-extended) vector
    function automatic int unsigned lowest_set(input logic [MAX_LINES-1:0] v);
        int unsigned r;
        r = 0;
        for (int i = MAX_LINES - 1; i >= 0; i--) begin
            if (v[i]) r = i;
        end
        return r;
    endfunction

endpackage

// File: rtl/flop_icache_match.sv
module flop_icache_match #(
    parameter int LINES = 4,
    parameter int TAG_W = 8
) (
    input  logic [LINES-1:0][TAG_W-1:0] tags,
    input  logic [LINES-1:0]            line_valid,
    input  logic [TAG_W-1:0]            probe,
    output logic [LINES-1:0]            hit_vec
);
    for (genvar g = 0; g < LINES; g++) begin : g_cmp
        assign hit_vec[g] = line_valid[g] && (tags[g] == probe);
    end
endmodule

// File: rtl/flop_icache_lru.sv
module flop_icache_lru #(
    parameter  int LINES = 4,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             touch,
    input  logic [IDX_W-1:0] touch_idx,
    input  logic [LINES-1:0] line_valid,
    output logic [IDX_W-1:0] victim_idx
);
    // rank 0 = most recent, LINES-1 = least recent
    logic [LINES-1:0][IDX_W-1:0] rank_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LINES; i++) rank_q[i] <= IDX_W'(i);
        end else if (touch) begin
            for (int i = 0; i < LINES; i++) begin
                if (IDX_W'(i) == touch_idx)
                    rank_q[i] <= '0;
                else if (rank_q[i] < rank_q[touch_idx])
                    rank_q[i] <= rank_q[i] + 1'b1;
            end
        end
    end

    always_comb begin
        logic found;
        found      = 1'b0;
        victim_idx = '0;
        for (int i = 0; i < LINES; i++) begin
            if (!line_valid[i] && !found) begin
                victim_idx = IDX_W'(i);
                found      = 1'b1;
            end
        end
        if (!found) begin
            for (int i = 0; i < LINES; i++) begin
                if (rank_q[i] == IDX_W'(LINES - 1)) victim_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/flop_icache_fill.sv
module flop_icache_fill
    import flop_icache_pkg::*;
#(
    parameter int WA_W  = 22,
    parameter int OFF_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [WA_W-1:0]  start_word,
    input  logic             mem_ack,
    input  logic             mem_rvalid,
    output fill_state_e      state,
    output logic             req,
    output logic [WA_W-1:0]  pend_word,
    output logic             beat_we,
    output logic [OFF_W-1:0] beat_off,
    output logic             beat_first,
    output logic             beat_last
);
    localparam int WPL = 1 << OFF_W;

    fill_state_e      state_q;
    logic [WA_W-1:0]  pend_q;
    logic [OFF_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FS_IDLE;
            pend_q  <= '0;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                FS_IDLE: if (start) begin
                    state_q <= FS_REQ;
                    pend_q  <= start_word;
                    cnt_q   <= '0;
                end
                FS_REQ: if (mem_ack) state_q <= FS_FILL;
                FS_FILL: if (mem_rvalid) begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == OFF_W'(WPL - 1)) state_q <= FS_IDLE;
                end
                default: state_q <= FS_IDLE;
            endcase
        end
    end

    assign state      = state_q;
    assign req        = (state_q == FS_REQ);
    assign pend_word  = pend_q;
    assign beat_we    = (state_q == FS_FILL) && mem_rvalid;
    assign beat_off   = pend_q[OFF_W-1:0] + cnt_q;   // wraps within the line
    assign beat_first = (cnt_q == '0);
    assign beat_last  = (cnt_q == OFF_W'(WPL - 1));
endmodule

// File: rtl/flop_icache.sv
module flop_icache
    import flop_icache_pkg::*;
#(
    parameter int LINES     = 4,
    parameter int LINE_BITS = 128,
    parameter int ADDR_W    = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic [31:0]       fetch_data,
    output logic              fetch_wait,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    input  logic              maint_valid,
    input  logic              maint_all,
    input  logic [ADDR_W-1:0] maint_addr
);
    localparam int WPL   = int'(words_per_line(LINE_BITS));
    localparam int OFF_W = $clog2(WPL);
    localparam int WA_W  = ADDR_W - BYTE_OFF;
    localparam int TAG_W = WA_W - OFF_W;
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;

    // address split
    logic [WA_W-1:0]  fetch_word;
    logic [TAG_W-1:0] fetch_tag, maint_tag;
    logic [OFF_W-1:0] fetch_off;
    maint_cmd_t       mcmd;

    assign fetch_word = fetch_addr[ADDR_W-1:BYTE_OFF];
    assign fetch_tag  = fetch_word[WA_W-1:OFF_W];
    assign fetch_off  = fetch_word[OFF_W-1:0];
    assign maint_tag  = maint_addr[ADDR_W-1:BYTE_OFF+OFF_W];
    assign mcmd       = '{valid: maint_valid, all: maint_all};

    // storage
    logic [LINES-1:0][TAG_W-1:0]          tags_q;
    logic [LINES-1:0]                     valid_q, valid_d;
    logic [LINES-1:0][WPL-1:0][WORD_BITS-1:0] data_q;
    logic [IDX_W-1:0]                     fill_idx_q;
    logic                                 kill_q;

    // lookup
    logic [LINES-1:0] hit_vec, maint_vec;
    logic             hit;
    logic [IDX_W-1:0] hit_idx;

    flop_icache_match #(.LINES(LINES), .TAG_W(TAG_W)) i_fetch_match (
        .tags(tags_q), .line_valid(valid_q), .probe(fetch_tag), .hit_vec(hit_vec)
    );

    flop_icache_match #(.LINES(LINES), .TAG_W(TAG_W)) i_maint_match (
        .tags(tags_q), .line_valid(valid_q), .probe(maint_tag), .hit_vec(maint_vec)
    );

    assign hit     = fetch_valid && (|hit_vec);
    assign hit_idx = IDX_W'(lowest_set(MAX_LINES'(hit_vec)));

    // fill control
    fill_state_e      fstate;
    logic             start, beat_we, beat_first, beat_last;
    logic [WA_W-1:0]  pend_word;
    logic [OFF_W-1:0] beat_off;
    logic             busy, fwd, kill_now;
    logic [IDX_W-1:0] victim_idx;

    assign start = fetch_valid && !hit && (fstate == FS_IDLE);
    assign busy  = (fstate != FS_IDLE);

    flop_icache_fill #(.WA_W(WA_W), .OFF_W(OFF_W)) i_fill (
        .clk(clk), .rst(rst), .start(start), .start_word(fetch_word),
        .mem_ack(mem_ack), .mem_rvalid(mem_rvalid), .state(fstate),
        .req(mem_req), .pend_word(pend_word), .beat_we(beat_we),
        .beat_off(beat_off), .beat_first(beat_first), .beat_last(beat_last)
    );

    assign mem_addr = {pend_word, {BYTE_OFF{1'b0}}};

    flop_icache_lru #(.LINES(LINES)) i_lru (
        .clk(clk), .rst(rst),
        .touch(hit || start),
        .touch_idx(hit ? hit_idx : victim_idx),
        .line_valid(valid_q),
        .victim_idx(victim_idx)
    );

    // critical word forwarding
    assign fwd = beat_we && beat_first && fetch_valid && (fetch_word == pend_word);

    assign fetch_wait = fetch_valid && !hit && !fwd;
    assign fetch_data = fwd ? mem_rdata : data_q[hit_idx][fetch_off];

    // maintenance that lands on the line under fill
    assign kill_now = busy && mcmd.valid &&
                      (mcmd.all || (maint_tag == tags_q[fill_idx_q]));

    always_comb begin
        valid_d = valid_q;
        if (beat_we && beat_last && !kill_q && !kill_now)
            valid_d[fill_idx_q] = 1'b1;
        if (start)
            valid_d[victim_idx] = 1'b0;
        if (mcmd.valid) begin
            if (mcmd.all) valid_d = '0;
            else          valid_d = valid_d & ~maint_vec;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q    <= '0;
            tags_q     <= '0;
            fill_idx_q <= '0;
            kill_q     <= 1'b0;
        end else begin
            valid_q <= valid_d;
            if (start) begin
                tags_q[victim_idx] <= fetch_tag;
                fill_idx_q         <= victim_idx;
                kill_q             <= mcmd.valid && (mcmd.all || (maint_tag == fetch_tag));
            end else if (kill_now) begin
                kill_q <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (beat_we) data_q[fill_idx_q][beat_off] <= mem_rdata;
    end
endmodule

// File: rtl/flop_icache_chk.sv
module flop_icache_chk #(
    parameter int LINES  = 4,
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              fetch_valid,
    input logic              fetch_wait,
    input logic              mem_req,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              maint_valid,
    input logic              maint_all,
    input logic              fill_idle,
    input logic [LINES-1:0]  valid_q,
    input logic [LINES-1:0]  hit_vec,
    input logic [LINES-1:0]  maint_vec
);
    AST_ONE_LINE_HITS: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec)); // R2

    AST_HIT_NO_STALL: assert property (@(posedge clk) disable iff (rst)
        fetch_valid && (|hit_vec) |-> !fetch_wait); // R3

    AST_MISS_RAISES_REQ: assert property (@(posedge clk) disable iff (rst)
        fetch_valid && fetch_wait && fill_idle |=> mem_req); // R4

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr)); // R5

    AST_LINE_INVALIDATED: assert property (@(posedge clk) disable iff (rst)
        maint_valid && !maint_all |=> (valid_q & $past(maint_vec)) == '0); // R8

    AST_ALL_INVALIDATED: assert property (@(posedge clk) disable iff (rst)
        maint_valid && maint_all |=> valid_q == '0); // R9
endmodule

bind flop_icache flop_icache_chk #(.LINES(LINES), .ADDR_W(ADDR_W)) i_chk (
    .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_wait(fetch_wait),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
    .maint_valid(maint_valid), .maint_all(maint_all),
    .fill_idle(fstate == flop_icache_pkg::FS_IDLE),
    .valid_q(valid_q), .hit_vec(hit_vec), .maint_vec(maint_vec)
);

// File: tb/test_flop_icache.sv
module test_flop_icache;
    localparam int LINES = 4;
    localparam int LINE_BITS = 64;
    localparam int ADDR_W = 12;
    localparam int WPL = LINE_BITS / 32;

    logic clk = 0, rst = 1;
    logic fetch_valid = 0, mem_ack = 0, mem_rvalid = 0, maint_valid = 0, maint_all = 0;
    logic [ADDR_W-1:0] fetch_addr = '0, maint_addr = '0, mem_addr;
    logic [31:0] fetch_data, mem_rdata = '0;
    logic fetch_wait, mem_req;

    int checks = 0, fails = 0, reqs = 0, cur_beat = -1;
    bit done = 0;

    // bench model of residency
    logic [8:0] m_tag [LINES];
    bit         m_val [LINES];
    int         m_rank[LINES];

    always #4 clk = ~clk;

    flop_icache #(.LINES(LINES), .LINE_BITS(LINE_BITS), .ADDR_W(ADDR_W)) i_flop_icache (
        .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .fetch_data(fetch_data), .fetch_wait(fetch_wait), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .maint_valid(maint_valid), .maint_all(maint_all),
        .maint_addr(maint_addr)
    );

    function automatic logic [31:0] memword(input logic [9:0] wa);
        return {wa, 6'h2b, ~wa, 6'h15};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory side: 2-cycle accept delay, 2-cycle latency, wrapped beats
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req) begin
                logic [ADDR_W-1:0] cap;
                reqs++;
                cap = mem_addr;
                repeat (2) begin
                    @(negedge clk);
                    chk(mem_req && mem_addr == cap, "R5 request held", {20'b0, mem_addr}, {20'b0, cap});
                end
                mem_ack = 1;
                @(negedge clk);
                mem_ack = 0;
                repeat (2) @(negedge clk);
                for (int k = 0; k < WPL; k++) begin
                    logic [9:0] w;
                    w = cap[11:2];
                    w[0] = w[0] + k[0];
                    cur_beat = k;
                    mem_rvalid = 1;
                    mem_rdata = memword(w);
                    @(negedge clk);
                end
                mem_rvalid = 0;
                cur_beat = -1;
            end
        end
    end

    function automatic int m_lookup(input logic [8:0] t);
        for (int i = 0; i < LINES; i++) if (m_val[i] && m_tag[i] == t) return i;
        return -1;
    endfunction

    function automatic void m_touch(input int idx);
        int r;
        r = m_rank[idx];
        for (int i = 0; i < LINES; i++) if (m_rank[i] < r) m_rank[i]++;
        m_rank[idx] = 0;
    endfunction

    function automatic int m_victim();
        for (int i = 0; i < LINES; i++) if (!m_val[i]) return i;
        for (int i = 0; i < LINES; i++) if (m_rank[i] == LINES - 1) return i;
        return 0;
    endfunction

    // one fetch, checked against the model; returns 1 if it hit
    task automatic do_fetch(input logic [ADDR_W-1:0] a, input string tag, output bit was_hit);
        int idx, guard, r0;
        logic [31:0] expd;
        expd = memword(a[11:2]);
        idx = m_lookup(a[11:3]);
        r0 = reqs;
        @(negedge clk);
        fetch_valid = 1;
        fetch_addr = a;
        #1;
        was_hit = !fetch_wait;
        chk(was_hit == (idx >= 0), {tag, " hit/miss prediction"}, {31'b0, was_hit}, {31'b0, idx >= 0});
        if (!fetch_wait) begin
            chk(fetch_data == expd, {tag, " R3 hit data"}, fetch_data, expd);
            @(negedge clk);
            fetch_valid = 0;
            #1;
            chk(!mem_req && reqs == r0, {tag, " R3 no request on hit"}, {31'b0, mem_req}, 0);
            if (idx >= 0) m_touch(idx);
        end else begin
            @(negedge clk);
            #1;
            chk(mem_req && mem_addr == {a[11:2], 2'b00}, {tag, " R4 request address"},
                {19'b0, mem_req, mem_addr}, {19'b0, 1'b1, a[11:2], 2'b00});
            guard = 0;
            while (fetch_wait && guard < 100) begin
                @(negedge clk);
                #1;
                guard++;
            end
            chk(mem_rvalid && cur_beat == 0, {tag, " R6 released on first beat"}, cur_beat, 0);
            chk(fetch_data == expd, {tag, " R6 forwarded word"}, fetch_data, expd);
            @(negedge clk);
            fetch_valid = 0;
            repeat (5) @(negedge clk);
            if (idx < 0) begin
                int v;
                v = m_victim();
                m_touch(v);
                m_tag[v] = a[11:3];
                m_val[v] = 1;
            end
        end
    endtask

    task automatic do_maint(input bit all, input logic [ADDR_W-1:0] a);
        @(negedge clk);
        maint_valid = 1;
        maint_all = all;
        maint_addr = a;
        @(negedge clk);
        maint_valid = 0;
        maint_all = 0;
        for (int i = 0; i < LINES; i++)
            if (all || m_tag[i] == a[11:3]) m_val[i] = 0;
    endtask

    task automatic expect_hit(input logic [ADDR_W-1:0] a, input bit exp, input string tag);
        bit h;
        do_fetch(a, tag, h);
        chk(h == exp, tag, {31'b0, h}, {31'b0, exp});
    endtask

    initial begin
        for (int i = 0; i < LINES; i++) begin
            m_val[i] = 0;
            m_tag[i] = '0;
            m_rank[i] = i;
        end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        #1;
        chk(!mem_req && !fetch_wait, "R1 reset outputs", {30'b0, mem_req, fetch_wait}, 0);

        // R1: cold miss; R6: wrapped fill from an odd word
        expect_hit(12'h004, 0, "R1 cold miss");
        expect_hit(12'h000, 1, "R6 other word of line");
        expect_hit(12'h004, 1, "R3 repeat hit");

        // R2: four lines that agree in all low bits
        expect_hit(12'h100, 0, "R2 fill b");
        expect_hit(12'h200, 0, "R2 fill c");
        expect_hit(12'h304, 0, "R2 fill d");
        expect_hit(12'h000, 1, "R2 a resident");
        expect_hit(12'h104, 1, "R2 b resident");
        expect_hit(12'h200, 1, "R2 c resident");
        expect_hit(12'h300, 1, "R2 d resident");

        // R7: order now a,b,c,d used; touch a, new line evicts b
        expect_hit(12'h000, 1, "R7 touch a");
        expect_hit(12'h400, 0, "R7 new line");
        expect_hit(12'h000, 1, "R7 a kept");
        expect_hit(12'h100, 0, "R7 b evicted");

        // R8: single invalidate, others intact, refill takes the invalid slot
        do_maint(0, 12'h404);
        expect_hit(12'h000, 1, "R8 a untouched");
        expect_hit(12'h404, 0, "R8 invalidated line misses");
        expect_hit(12'h100, 1, "R7 b kept after refill of invalid slot");

        // R9: invalidate all
        do_maint(1, '0);
        expect_hit(12'h000, 0, "R9 a gone");
        expect_hit(12'h104, 0, "R9 b gone");

        // R10: invalidate all while a fill is pending
        fork
            begin
                bit h;
                do_fetch(12'h50c, "R10 fill under flush", h);
            end
            begin
                repeat (3) @(negedge clk);
                do_maint(1, '0);
            end
        join
        for (int i = 0; i < LINES; i++) m_val[i] = 0;
        expect_hit(12'h508, 0, "R10 killed line still invalid");

        // sweep over six lines with occasional invalidation
        begin
            logic [15:0] lf;
            lf = 16'hACE1;
            for (int n = 0; n < 300; n++) begin
                bit h;
                logic [ADDR_W-1:0] a;
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                a = {1'b0, 3'(lf[2:0] % 6), 5'b0, lf[3], 2'b00};
                if (lf[9:6] == 4'hF) do_maint(0, a);
                else do_fetch(a, "R7 sweep", h);
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule